// File: doc/BRIEF.md
# TLB Replacement Index Picker

This block picks which translation buffer entry to overwrite when a refill needs a slot chosen at random. A caller pulses a request and supplies two numbers: how many entries the buffer has, and how many entries at the bottom are locked. A few dozen cycles later the block pulses a valid strobe and presents an index. That index always points at an unlocked entry. It also never equals the index handed out just before it, so two refills in a row cannot land on the same slot.

Randomness comes from a 32-bit right-shifting Galois shift register. The register takes one step for every candidate the block tries. A sequential restoring divider reduces the register value modulo the number of unlocked entries, and the number of locked entries is then added. If the candidate repeats the last index, the register steps again and the block tries again. The only exception is when just one unlocked entry exists: that entry is returned anyway, so the block cannot loop forever.

Top module: `tlb_rand_index`

## Requirements
- R1: After reset the valid strobe is low, the index output is 0, the remembered previous index is 0 and the shift register holds 1.
- R2: Each candidate attempt advances the shift register exactly once: shift right by one, and if the bit shifted out was 1, XOR the result with 0xD0000001. The register keeps its state from one request to the next, whatever configuration each request uses.
- R3: Every returned index lies in the range from wired count up to entry count minus 1.
- R4: A returned index equals (register value mod (entry count − wired count)) + wired count, using the register value after the step that produced the accepted candidate.
- R5: When more than one unlocked entry exists, a returned index never equals the index returned by the previous request. The first request is compared against 0.
- R6: When entry count − wired count equals 1, the block returns the wired count on every request, even when it repeats, after a single register step.
- R7: The valid strobe is high for exactly one cycle per accepted request. A request or configuration change that arrives while a pick is in progress is ignored: it produces no second strobe and does not advance the register.
- R8: The entry count and wired count are captured when the request is accepted. Changing them while a pick is in progress does not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe; sampled only when idle |
| entry_count | input | 7 | Number of buffer entries (1 to 64) |
| wired_count | input | 6 | Number of locked low entries, less than entry_count |
| idx | output | 6 | Chosen entry index, held until the next pick |
| idx_valid | output | 1 | One-cycle strobe marking a new index |

## Verification
The bench sweeps every entry/wired pair up to 16 entries. It also runs long request streams at 64 entries, and against a bit-exact shift-register model it catches a design that steps the register too often or too rarely. A wrong tap constant or a wrong shift direction shows up as a mismatch on the very first index. The single-free-entry configurations expose a retry loop that hangs (seen as a timeout) or that takes extra steps (every later index then drifts from the model). A request sent mid-pick, together with altered configuration inputs, catches a design that re-arms or re-latches while busy: it would give a second strobe or an out-of-model index. Repeat checks against the index returned just before catch a missing or misupdated previous-index register.

// File: rtl/tlb_rand_index.sv
module tlb_rand_index #(
  parameter int unsigned            IDX_W  = 6,
  parameter int unsigned            LFSR_W = 32,
  parameter logic [LFSR_W-1:0]      SEED   = 32'h0000_0001,
  parameter logic [LFSR_W-1:0]      TAPS   = 32'hD000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [IDX_W:0]   entry_count,
  input  logic [IDX_W-1:0] wired_count,
  output logic [IDX_W-1:0] idx,
  output logic             idx_valid
);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam int unsigned BIT_W = $clog2(LFSR_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_DIV, S_CHECK} state_t;

  state_t             state;
  logic [LFSR_W-1:0]  lfsr, dvd;
  logic [CNT_W-1:0]   span, rem;
  logic [IDX_W-1:0]   base, prev;
  logic [BIT_W-1:0]   bits;

  wire [LFSR_W-1:0] lfsr_nxt = (lfsr >> 1) ^ (lfsr[0] ? TAPS : '0);
  wire              cfg_ok   = entry_count > CNT_W'(wired_count);
  wire [CNT_W-1:0]  span_in  = cfg_ok ? entry_count - CNT_W'(wired_count) : CNT_W'(1);
  wire [CNT_W-1:0]  rem_sh   = {rem[IDX_W-1:0], dvd[LFSR_W-1]};
  wire              rem_ge   = rem_sh >= span;
  wire [CNT_W-1:0]  cand     = rem + CNT_W'(base);
  wire              accept   = (cand != CNT_W'(prev)) || (span == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      lfsr      <= SEED;
      dvd       <= '0;
      span      <= CNT_W'(1);
      base      <= '0;
      rem       <= '0;
      bits      <= '0;
      prev      <= '0;
      idx       <= '0;
      idx_valid <= 1'b0;
    end else begin
      idx_valid <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          span  <= span_in;
          base  <= wired_count;
          state <= S_STEP;
        end
        S_STEP: begin
          lfsr  <= lfsr_nxt;
          dvd   <= lfsr_nxt;
          rem   <= '0;
          bits  <= '0;
          state <= S_DIV;
        end
        S_DIV: begin
          dvd  <= dvd << 1;
          rem  <= rem_ge ? rem_sh - span : rem_sh;
          bits <= bits + 1'b1;
          if (bits == BIT_W'(LFSR_W - 1)) state <= S_CHECK;
        end
        default: begin
          if (accept) begin
            idx       <= cand[IDX_W-1:0];
            prev      <= cand[IDX_W-1:0];
            idx_valid <= 1'b1;
            state     <= S_IDLE;
          end else begin
            state <= S_STEP;
          end
        end
      endcase
    end
  end

  assert_lfsr_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> (CNT_W'(idx) >= CNT_W'(base)) && (CNT_W'(idx) < CNT_W'(base) + span));

  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DIV || state == S_CHECK) |-> rem < span);

  assert_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && span != CNT_W'(1)) |-> idx != $past(prev));

  assert_single_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && span == CNT_W'(1)) |-> idx == base);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |=> !idx_valid);

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(span) && $stable(base));
endmodule

// File: tb/tlb_rand_index_test.sv
module tlb_rand_index_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [6:0] entry_count = 7'd1;
  logic [5:0] wired_count = 6'd0;
  logic [5:0] idx;
  logic       idx_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit [31:0] m_lfsr = 32'd1;
  int m_prev = 0;

  always #2 clk = ~clk;

  tlb_rand_index uut (
    .clk(clk), .rst_n(rst_n), .req(req),
    .entry_count(entry_count), .wired_count(wired_count),
    .idx(idx), .idx_valid(idx_valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] step(input bit [31:0] v);
    return (v >> 1) ^ (v[0] ? 32'hD000_0001 : 32'h0);
  endfunction

  function automatic int model_pick(input int ent, input int wir);
    bit [31:0] span = 32'(ent - wir);
    int c;
    do begin
      m_lfsr = step(m_lfsr);
      c = int'(m_lfsr % span) + wir;
    end while (c == m_prev && span != 32'd1);
    return c;
  endfunction

  task automatic pick(input int ent, input int wir, input bit poke_busy);
    int exp, old_prev, n;
    @(negedge clk);
    entry_count = 7'(ent);
    wired_count = 6'(wir);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      entry_count = 7'd64;
      wired_count = 6'd0;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    old_prev = m_prev;
    exp = model_pick(ent, wir);
    n = 0;
    while (!idx_valid && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!idx_valid) begin
      check(1'b0, "R7 timeout waiting for strobe", 0, 1);
      m_prev = exp;
      return;
    end
    check(int'(idx) == exp, poke_busy ? "R8 value with busy inputs" : "R4 model match", int'(idx), exp);
    check(int'(idx) >= wir && int'(idx) < ent, "R3 range", int'(idx), wir);
    if (ent - wir > 1)
      check(int'(idx) != old_prev, "R5 back-to-back repeat", int'(idx), old_prev);
    else
      check(int'(idx) == wir, "R6 single free entry", int'(idx), wir);
    m_prev = exp;
    @(negedge clk);
    check(!idx_valid, "R7 strobe one cycle", int'(idx_valid), 0);
    if (poke_busy) begin
      n = 0;
      repeat (80) begin
        @(negedge clk);
        if (idx_valid) n++;
      end
      check(n == 0, "R7 busy request ignored", n, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!idx_valid, "R1 reset strobe", int'(idx_valid), 0);
    check(idx == 6'd0, "R1 reset index", int'(idx), 0);
    rst_n = 1'b1;
    // R1/R2: first pick from seed 1 with previous index 0
    pick(8, 0, 1'b0);
    for (int e = 1; e <= 16; e++)
      for (int w = 0; w < e; w++)
        repeat (2) pick(e, w, 1'b0);
    // R6: single free slot repeated
    repeat (5) pick(64, 63, 1'b0);
    repeat (4) pick(2, 1, 1'b0);
    // R5: two slots must alternate
    repeat (10) pick(2, 0, 1'b0);
    // R2: long stream with full table
    repeat (60) pick(64, 0, 1'b0);
    repeat (20) pick(64, 17, 1'b0);
    // R7/R8: requests and config changes while busy
    repeat (4) pick(5, 2, 1'b1);
    pick(33, 30, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule